// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This peripheral holds four independent down-counters behind a small register interface: an address, a write-data word, write and read strobes, and a read-data word. The two lower channels are 24 bits wide and the two upper channels are 32 bits wide. Each channel has a reload register and a live count register. Its enable and mode bits sit side by side in one shared control word. Software preloads a count while the channel is stopped, sets the enable bit, and then either lets the channel expire once or lets it refill from its reload register each time it wraps.

On every clock, each channel makes one decision from its enable bit, its mode bit and its present count. It can hold, step down by one, refill from its reload register, or expire to zero. A refill or an expiry is a terminal event. It latches that channel's pending flag in the interrupt register. A single interrupt output is raised while any pending flag has its matching enable bit set. Software clears flags by writing ones to them, so reading the interrupt register and writing the same word back acknowledges every flag that was observed.

Top module: `quad_downcount_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Register offsets: control at 0x00, interrupt register at 0x04, reload of channel t at 0x10+4t, live count of channel t at 0x20+4t. Any other offset reads zero. `bus_rdata` is zero while `bus_rd` is low.
- R3: Channels 0 and 1 keep 24 bits, and channels 2 and 3 keep 32 bits. Above a channel's width, its reload and count registers read zero and discard written bits.
- R4: In the control word, bit 2t enables channel t and bit 2t+1 selects its mode (1 = auto-refill, 0 = single run). Bits 8 to 11 are plain read/write storage with no effect on counting. Bits 12 and up read zero.
- R5: An enabled channel whose count is above one loses exactly one per clock. A disabled channel keeps its count. Writing 0 to the control word stops all channels.
- R6: In single-run mode, a count of 1 becomes 0 and sets the pending flag. A count of 0 then stays at 0 and sets no further flags.
- R7: In auto-refill mode, a count of 1 or 0 is replaced by the reload value and sets the pending flag. A reload value of N gives one flag every N clocks, and a reload value of 0 flags on every clock.
- R8: A write to a live count register takes effect only if that channel's enable bit was clear before the write. Otherwise the write is discarded.
- R9: In the interrupt register, bits 3:0 are read/write interrupt enables and bits 7:4 are the pending flags of channels 0 to 3. Writing 1 to a flag clears it, and writing 0 leaves it unchanged.
- R10: If a terminal event and a clearing write hit the same flag in the same clock, the flag ends up set.
- R11: `irq` is high exactly when some pending flag and its enable are both set. It rises in the clock after the edge that set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, acts at the rising edge |
| bus_rd | input | 1 | Read strobe, gates the read data |
| bus_rdata | output | 32 | Read data, combinational from the registers |
| irq | output | 1 | Combined interrupt request |

## Verification
A channel that takes the wrong decision shows up in its live count register one clock later, as a step that is missing, extra or refilled. Its pending flag also differs within that same clock, and `irq` differs in the following cycle if the flag is enabled. A flag that is dropped or cleared wrongly appears on `irq` one cycle after the edge concerned. Every register is therefore compared with a model on each read, and `irq` is compared with the model on every clock. Terminal events that collide with acknowledge writes are provoked on purpose with a reload value of zero.

// File: rtl/qdt_pkg.sv
package qdt_pkg;

    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_IRQ    = 'h04;
    localparam int OFF_RELOAD = 'h10;
    localparam int OFF_COUNT  = 'h20;
    localparam int REG_STRIDE = 4;

    // per-clock decision of one channel
    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_STEP,
        ACT_REFILL,
        ACT_EXPIRE
    } lane_act_e;

    // lower half of the channels are narrow, upper half wide
    function automatic int lane_width(input int idx, input int n_ch,
                                      input int narrow_w, input int wide_w);
        return (idx < n_ch / 2) ? narrow_w : wide_w;
    endfunction

endpackage

// File: rtl/qdt_lane.sv
module qdt_lane #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         periodic,
    input  logic [W-1:0] reload_val,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         hit
);
    import qdt_pkg::*;

    logic [W-1:0] count_q;
    lane_act_e    act;
    logic         at_edge;

    assign at_edge = (count_q == '0) || (count_q == W'(1));

    always_comb begin
        if (!run) begin
            act = ACT_HOLD;
        end else if (periodic) begin
            act = at_edge ? ACT_REFILL : ACT_STEP;
        end else if (count_q == W'(1)) begin
            act = ACT_EXPIRE;
        end else if (count_q == '0) begin
            act = ACT_HOLD;
        end else begin
            act = ACT_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_en) begin
            count_q <= load_val;
        end else begin
            unique case (act)
                ACT_HOLD:   count_q <= count_q;
                ACT_STEP:   count_q <= count_q - W'(1);
                ACT_REFILL: count_q <= reload_val;
                ACT_EXPIRE: count_q <= '0;
            endcase
        end
    end

    assign hit   = (act == ACT_REFILL) || (act == ACT_EXPIRE);
    assign count = count_q;

endmodule

// File: rtl/qdt_irq.sv
module qdt_irq #(
    parameter int N_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [2*N_CH-1:0] wdata,
    input  logic [N_CH-1:0]   hit,
    output logic [N_CH-1:0]   ie,
    output logic [N_CH-1:0]   pend,
    output logic              irq
);
    logic [N_CH-1:0] ie_q, pend_q, clr;

    assign clr = wr ? wdata[2*N_CH-1:N_CH] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= '0;
            pend_q <= '0;
        end else begin
            if (wr) ie_q <= wdata[N_CH-1:0];
            pend_q <= (pend_q & ~clr) | hit;   // set beats clear
        end
    end

    assign ie   = ie_q;
    assign pend = pend_q;
    assign irq  = |(pend_q & ie_q);

endmodule

// File: rtl/quad_downcount_timer.sv
module quad_downcount_timer #(
    parameter int N_CH     = 4,
    parameter int NARROW_W = 24,
    parameter int WIDE_W   = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    import qdt_pkg::*;

    localparam int CTRL_W = 3 * N_CH;   // enable/mode pairs plus source bits

    logic [CTRL_W-1:0]             ctrl_q;
    logic [N_CH-1:0]               ie_q, pend_q, hit_vec;
    logic [N_CH-1:0][DATA_W-1:0]   cnt_vec, reload_vec;
    logic                          wr_ctrl, wr_irq;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
    assign wr_irq  = bus_wr && (bus_addr == ADDR_W'(OFF_IRQ));

    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam int LW = lane_width(c, N_CH, NARROW_W, WIDE_W);
        localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(OFF_RELOAD + REG_STRIDE * c);
        localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFF_COUNT + REG_STRIDE * c);

        logic [LW-1:0] reload_q, lane_cnt;
        logic          wr_cnt;

        assign wr_cnt = bus_wr && (bus_addr == A_CNT) && !ctrl_q[2*c];

        always_ff @(posedge clk) begin
            if (!rst_n)                              reload_q <= '0;
            else if (bus_wr && (bus_addr == A_RLD))  reload_q <= bus_wdata[LW-1:0];
        end

        qdt_lane #(.W(LW)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (ctrl_q[2*c]),
            .periodic   (ctrl_q[2*c+1]),
            .reload_val (reload_q),
            .load_en    (wr_cnt),
            .load_val   (bus_wdata[LW-1:0]),
            .count      (lane_cnt),
            .hit        (hit_vec[c])
        );

        assign cnt_vec[c]    = DATA_W'(lane_cnt);
        assign reload_vec[c] = DATA_W'(reload_q);
    end

    qdt_irq #(.N_CH(N_CH)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_irq),
        .wdata (bus_wdata[2*N_CH-1:0]),
        .hit   (hit_vec),
        .ie    (ie_q),
        .pend  (pend_q),
        .irq   (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata = DATA_W'(ctrl_q);
            if (bus_addr == ADDR_W'(OFF_IRQ))  bus_rdata = DATA_W'({pend_q, ie_q});
            for (int c = 0; c < N_CH; c++) begin
                if (bus_addr == ADDR_W'(OFF_RELOAD + REG_STRIDE * c)) bus_rdata = reload_vec[c];
                if (bus_addr == ADDR_W'(OFF_COUNT + REG_STRIDE * c))  bus_rdata = cnt_vec[c];
            end
        end
    end

endmodule

// File: rtl/qdt_checker.sv
module qdt_checker #(
    parameter int N_CH   = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_wr,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [2*N_CH-1:0]           ctrl_q,
    input logic [N_CH-1:0]             pend_q,
    input logic [N_CH-1:0]             hit_vec,
    input logic [N_CH-1:0][DATA_W-1:0] cnt_vec,
    input logic                        irq
);
    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'('h20 + 4 * c);

        p_pend_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[c] |=> pend_q[c]);

        p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[2*c] && cnt_vec[c] > DATA_W'(1)) |=> cnt_vec[c] == $past(cnt_vec[c]) - DATA_W'(1));

        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_q[2*c] && !(bus_wr && bus_addr == A_CNT)) |=> $stable(cnt_vec[c]));

        p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[2*c] && !ctrl_q[2*c+1] && cnt_vec[c] == '0) |=> cnt_vec[c] == '0);

        p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_q[2*c] |-> !hit_vec[c]);
    end

    p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|hit_vec) || $past(bus_wr && bus_addr == ADDR_W'('h04))));

endmodule

bind quad_downcount_timer qdt_checker #(.N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_qdt_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .ctrl_q   (ctrl_q[2*N_CH-1:0]),
    .pend_q   (pend_q),
    .hit_vec  (hit_vec),
    .cnt_vec  (cnt_vec),
    .irq      (irq)
);

// File: tb/quad_downcount_timer_bench.sv
module quad_downcount_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #5 clk = ~clk;

    quad_downcount_timer u_quad_downcount_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    logic [11:0] m_ctrl;
    logic [3:0]  m_ie, m_pend;
    logic [31:0] m_rel [4];
    logic [31:0] m_cnt [4];

    function automatic logic [31:0] wmask(input int c);
        return (c < 2) ? 32'h00FF_FFFF : 32'hFFFF_FFFF;
    endfunction

    always @(posedge clk) begin : model
        logic [31:0] nc [4];
        logic [3:0]  h;
        logic [3:0]  clr;
        if (!rst_n) begin
            m_ctrl = '0; m_ie = '0; m_pend = '0;
            for (int c = 0; c < 4; c++) begin m_rel[c] = '0; m_cnt[c] = '0; end
        end else begin
            h = '0;
            for (int c = 0; c < 4; c++) begin
                nc[c] = m_cnt[c];
                if (m_ctrl[2*c]) begin
                    if (m_ctrl[2*c+1]) begin
                        if (m_cnt[c] <= 1) begin nc[c] = m_rel[c]; h[c] = 1'b1; end
                        else nc[c] = m_cnt[c] - 1;
                    end else begin
                        if (m_cnt[c] == 1) begin nc[c] = 0; h[c] = 1'b1; end
                        else if (m_cnt[c] != 0) nc[c] = m_cnt[c] - 1;
                    end
                end
                if (bus_wr && bus_addr == 8'(32'h20 + 4*c) && !m_ctrl[2*c])
                    nc[c] = bus_wdata & wmask(c);
                if (bus_wr && bus_addr == 8'(32'h10 + 4*c))
                    m_rel[c] = bus_wdata & wmask(c);
            end
            clr = (bus_wr && bus_addr == 8'h04) ? bus_wdata[7:4] : 4'h0;
            m_pend = (m_pend & ~clr) | h;
            if (bus_wr && bus_addr == 8'h04) m_ie = bus_wdata[3:0];
            if (bus_wr && bus_addr == 8'h00) m_ctrl = bus_wdata[11:0];
            for (int c = 0; c < 4; c++) m_cnt[c] = nc[c];
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] v;
        v = '0;
        if (a == 8'h00) v = {20'h0, m_ctrl};
        if (a == 8'h04) v = {24'h0, m_pend, m_ie};
        for (int c = 0; c < 4; c++) begin
            if (a == 8'(32'h10 + 4*c)) v = m_rel[c];
            if (a == 8'(32'h20 + 4*c)) v = m_cnt[c];
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // interrupt line compared with the model on every clock (R11)
    always @(negedge clk) begin
        if (rst_n && mon_on && !done)
            check("R11 irq", {31'h0, irq}, {31'h0, |(m_pend & m_ie)});
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 check(req, bus_rdata, model_read(a));
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            done = 1'b1;
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: reset values
        foreach (m_rel[i]) begin end
        rd(8'h00, "R1 ctrl"); rd(8'h04, "R1 irqreg");
        for (int c = 0; c < 4; c++) begin
            rd(8'(32'h10 + 4*c), "R1 reload");
            rd(8'(32'h20 + 4*c), "R1 count");
        end
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R2: unmapped offsets and read strobe low
        rd(8'h08, "R2 hole"); rd(8'h30, "R2 hole");
        wr(8'h14, 32'h1234);
        @(negedge clk); bus_addr = 8'h14; bus_rd = 1'b0;
        #1 check("R2 rd low", bus_rdata, 32'h0);
        rd(8'h14, "R2 reload1");

        // R3: width clipping
        wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, "R3 narrow reload");
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, "R3 wide reload");
        wr(8'h20, 32'hABCD_EF12); rd(8'h20, "R3 narrow count");
        wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, "R3 wide count");
        wr(8'h28, 32'h0);

        // R4: source bits are storage only, upper bits read zero
        wr(8'h00, 32'hFFFF_FF00); rd(8'h00, "R4 ctrl");
        idle(3); rd(8'h20, "R4 no count");
        wr(8'h00, 32'h0);

        // R5/R6: single run on channel 1
        wr(8'h24, 32'd6); wr(8'h04, 32'h2); wr(8'h00, 32'h04);
        rd(8'h24, "R5 step"); rd(8'h24, "R5 step");
        idle(6);
        rd(8'h24, "R6 expired"); rd(8'h04, "R6 flag");

        // R9: read-and-write-back acknowledge
        wr(8'h04, 32'h22); rd(8'h04, "R9 cleared");
        idle(4); rd(8'h04, "R6 no reflag");
        wr(8'h04, 32'h0A); rd(8'h04, "R9 ie write");

        // R8: count write while enabled is dropped
        wr(8'h24, 32'h55); rd(8'h24, "R8 ignored");

        // R7: auto-refill on channel 3, period 4
        wr(8'h1C, 32'd4); wr(8'h2C, 32'd4); wr(8'h00, 32'hC4);
        for (int i = 0; i < 10; i++) rd(8'h2C, "R7 refill");
        rd(8'h04, "R7 flag");

        // R10: channel 2 auto-refill with zero reload flags every clock
        wr(8'h18, 32'h0); wr(8'h00, 32'hF4);
        idle(2);
        wr(8'h04, 32'hF0); rd(8'h04, "R10 set wins");
        idle(3);  // R11: flags pending but masked, irq must stay low
        rd(8'h04, "R11 masked");

        // R5: global stop holds counts
        wr(8'h00, 32'h0);
        rd(8'h2C, "R5 hold"); idle(5); rd(8'h2C, "R5 hold");
        rd(8'h24, "R5 hold");
        wr(8'h04, 32'hF0); rd(8'h04, "R9 all clear");

        // R8: preload accepted while disabled, then restart single run
        wr(8'h24, 32'h0100_0002); rd(8'h24, "R8 preload");
        wr(8'h04, 32'h2); wr(8'h00, 32'h04);
        idle(4); rd(8'h04, "R6 flag again");
        check("R11 irq up", {31'h0, irq}, 32'h1);

        idle(2);
        done = 1'b1;
        report();
        $finish;
    end

endmodule